// File: doc/BRIEF.md
# Strap-Configured Registered Command/Address Buffer

This block registers the command and address lines of a memory module on the rising clock edge and drives them to the devices. Two straps, held constant while the block runs, select the layout. In the wide layout every input bit has one output. In the duplicated layout a narrower set of bits is registered and each stored bit drives two outputs. The second strap picks one of two fixed arrangements for that duplication.

Two active-low select inputs gate the register stage. When both are high the register keeps its contents and the outputs do not move. The first select is also registered and brought out, so it acts as one more data line. The active-low reset clears everything at once. A three-state sequencer releases reset in step with the clock.

The sequencer has three states. ST_RESET is entered at once whenever reset is low. On each rising edge with reset high it moves from ST_RESET to ST_WAKE, then from ST_WAKE to ST_RUN, and it stays in ST_RUN until reset falls again. Data is captured only in ST_RUN.

Top module: `cfg_regbuf`

## Requirements
- R1: With mode_dup=0, each rising edge in the run state with capture enabled stores din, and after that edge q_o[i]=din[i] for i in 0..24.
- R2: With mode_dup=0, output bits q_o[27:25] are always 0.
- R3: With mode_dup=1 and arr_sel=0 (arrangement A), stored bit k (k=0..13) is din[k], and q_o[k] and q_o[14+k] both show it.
- R4: With mode_dup=1 and arr_sel=1 (arrangement B), stored bit k (k=0..13) is din[11+k], and q_o[2k] and q_o[2k+1] both show it.
- R5: A rising edge at which cs0_n=1 and cs1_n=1 leaves q_o and cs_q_n unchanged.
- R6: A rising edge at which cs0_n or cs1_n is 0 updates the register, and cs_q_n then equals the value cs0_n had at that edge.
- R7: While rst_n is low, q_o and cs_q_n are 0 without waiting for a clock edge, and reset overrides the select gating.
- R8: After rst_n rises, the sequencer goes from ST_RESET to ST_WAKE to ST_RUN on the next two rising edges. The outputs stay 0 through those two edges, and the third edge is the first capture.
- R9: With cs1_n held at 0, every edge captures, and cs_q_n follows cs0_n one edge later whatever value cs0_n has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| mode_dup | input | 1 | Strap: 0 = 25-bit one-to-one, 1 = 14-bit duplicated |
| arr_sel | input | 1 | Strap: duplicated arrangement, 0 = A, 1 = B |
| din | input | 25 | Command/address data inputs |
| cs0_n | input | 1 | First active-low select, also registered as data |
| cs1_n | input | 1 | Second active-low select |
| q_o | output | 28 | Registered output bus |
| cs_q_n | output | 1 | Registered copy of cs0_n |

## Verification
A wrong stored bit shows on q_o one edge after the capture. In the duplicated layouts it shows on both copies, so a broken copy mapping shows up as a mismatched pair in the same cycle. If the sequencer is stuck or skips a state, the first capture after reset comes on the wrong edge, and this is visible within three cycles of the release. If the gating is wrong, the outputs change on an edge where both selects were high, and the next sample shows it.

// File: rtl/cfgbuf_pkg.sv
`timescale 1ns/1ps
package cfgbuf_pkg;
    localparam int WIDE_DEF = 25;
    localparam int DUP_DEF  = 14;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_WAKE  = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cfgbuf_seq.sv
`timescale 1ns/1ps
module cfgbuf_seq
    import cfgbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic live
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_WAKE;
            ST_WAKE:  state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_RESET;
        endcase
    end

    always_comb begin
        live = 1'b0;
        unique case (state_q)
            ST_RUN:           live = 1'b1;
            ST_RESET, ST_WAKE: live = 1'b0;
            default:          live = 1'b0;
        endcase
    end

    // R8: release walks through the wake state to run
    a_r8_reset_to_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) |=> (state_q == ST_WAKE));
    a_r8_wake_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q == ST_RUN));
endmodule

// File: rtl/cfgbuf_capture.sv
`timescale 1ns/1ps
module cfgbuf_capture #(
    parameter int WIDE_W = 25,
    parameter int DUP_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  logic              mode_dup,
    input  logic              arr_sel,
    input  logic [WIDE_W-1:0] din,
    input  logic              cs0_n,
    input  logic              cs1_n,
    output logic [WIDE_W-1:0] r_q,
    output logic              cs_r_q
);
    localparam int B_OFS = WIDE_W - DUP_W;

    logic [WIDE_W-1:0] sel;
    logic              en;

    assign en = !(cs0_n && cs1_n);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_sel
        if (i < DUP_W) begin : g_dup
            assign sel[i] = !mode_dup ? din[i] : (arr_sel ? din[B_OFS+i] : din[i]);
        end else begin : g_wide
            assign sel[i] = mode_dup ? 1'b0 : din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            cs_r_q <= 1'b0;
        end else if (!live) begin
            r_q    <= '0;
            cs_r_q <= 1'b0;
        end else if (en) begin
            r_q    <= sel;
            cs_r_q <= cs0_n;
        end
    end

    // R5: both selects high freeze the stage
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cs0_n && cs1_n) |=> ($stable(r_q) && $stable(cs_r_q)));
    // R6: any select low loads the stage
    a_r6_update: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !(cs0_n && cs1_n)) |=> (r_q == $past(sel) && cs_r_q == $past(cs0_n)));
endmodule

// File: rtl/cfgbuf_fanout.sv
`timescale 1ns/1ps
module cfgbuf_fanout #(
    parameter int WIDE_W = 25,
    parameter int DUP_W  = 14,
    parameter int OUT_W  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dup,
    input  logic              arr_sel,
    input  logic [WIDE_W-1:0] r_q,
    output logic [OUT_W-1:0]  q_o
);
    for (genvar j = 0; j < OUT_W; j++) begin : g_out
        logic w_bit, a_bit, b_bit;
        if (j < WIDE_W) begin : g_w
            assign w_bit = r_q[j];
        end else begin : g_wz
            assign w_bit = 1'b0;
        end
        if (j < 2*DUP_W) begin : g_d
            assign a_bit = r_q[j % DUP_W];
            assign b_bit = r_q[j / 2];
        end else begin : g_dz
            assign a_bit = 1'b0;
            assign b_bit = 1'b0;
        end
        assign q_o[j] = !mode_dup ? w_bit : (arr_sel ? b_bit : a_bit);
    end

    for (genvar k = 0; k < DUP_W; k++) begin : g_chk
        // R3: arrangement A copies sit one half apart
        a_r3_copy_a: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_dup && !arr_sel) |-> (q_o[k] == q_o[DUP_W+k]));
        // R4: arrangement B copies sit side by side
        a_r4_copy_b: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_dup && arr_sel) |-> (q_o[2*k] == q_o[2*k+1]));
    end

    if (OUT_W > WIDE_W) begin : g_pad
        // R2: spare positions low in one-to-one layout
        a_r2_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_dup |-> (q_o[OUT_W-1:WIDE_W] == '0));
    end
endmodule

// File: rtl/cfg_regbuf.sv
`timescale 1ns/1ps
module cfg_regbuf
    import cfgbuf_pkg::*;
#(
    parameter int WIDE_W = WIDE_DEF,
    parameter int DUP_W  = DUP_DEF,
    localparam int OUT_W = (WIDE_W > 2*DUP_W) ? WIDE_W : 2*DUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dup,
    input  logic              arr_sel,
    input  logic [WIDE_W-1:0] din,
    input  logic              cs0_n,
    input  logic              cs1_n,
    output logic [OUT_W-1:0]  q_o,
    output logic              cs_q_n
);
    logic              live;
    logic [WIDE_W-1:0] r_q;

    cfgbuf_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live)
    );

    cfgbuf_capture #(.WIDE_W(WIDE_W), .DUP_W(DUP_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .mode_dup (mode_dup),
        .arr_sel  (arr_sel),
        .din      (din),
        .cs0_n    (cs0_n),
        .cs1_n    (cs1_n),
        .r_q      (r_q),
        .cs_r_q   (cs_q_n)
    );

    cfgbuf_fanout #(.WIDE_W(WIDE_W), .DUP_W(DUP_W), .OUT_W(OUT_W)) u_fan (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_dup (mode_dup),
        .arr_sel  (arr_sel),
        .r_q      (r_q),
        .q_o      (q_o)
    );

    // R7: a cycle spent in reset leaves every output low
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0 && cs_q_n == 1'b0));
endmodule

// File: tb/tb_cfg_regbuf.sv
`timescale 1ns/1ps
module tb_cfg_regbuf;
    localparam int W = 25;
    localparam int N = 14;
    localparam int O = 28;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_dup = 1'b0;
    logic         arr_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic         cs0_n = 1'b0;
    logic         cs1_n = 1'b0;
    logic [O-1:0] q_o;
    logic         cs_q_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [W-1:0] m_r;
    logic         m_cs;
    logic [31:0]  seed = 32'h1234_5678;

    cfg_regbuf dut (
        .clk(clk), .rst_n(rst_n), .mode_dup(mode_dup), .arr_sel(arr_sel),
        .din(din), .cs0_n(cs0_n), .cs1_n(cs1_n), .q_o(q_o), .cs_q_n(cs_q_n)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] capt(logic [W-1:0] d, logic nar, logic b);
        logic [W-1:0] r = '0;
        if (!nar) r = d;
        else for (int k = 0; k < N; k++) r[k] = b ? d[W-N+k] : d[k];
        return r;
    endfunction

    function automatic logic [O-1:0] expq(logic [W-1:0] r, logic nar, logic b);
        logic [O-1:0] q = '0;
        if (!nar) q[W-1:0] = r;
        else for (int k = 0; k < N; k++) begin
            if (b) begin q[2*k] = r[k]; q[2*k+1] = r[k]; end
            else   begin q[k] = r[k]; q[N+k] = r[k]; end
        end
        return q;
    endfunction

    task automatic chk(string req, logic [O-1:0] act, logic [O-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg(bit nar, bit b, bit async_chk);
        @(negedge clk);
        rst_n = 1'b0;
        mode_dup = nar; arr_sel = b;
        din = 25'h1AB_CDEF; cs0_n = 1'b0; cs1_n = 1'b0;
        if (async_chk) begin
            #1;
            chk("R7 async clear q", q_o, '0);
            chk("R7 async clear cs", {27'd0, cs_q_n}, '0);
        end
        repeat (3) @(negedge clk);
        chk("R7 reset hold", {q_o[O-2:0], cs_q_n}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 low after first edge", q_o, '0);
        @(negedge clk);
        chk("R8 low after second edge", q_o, '0);
        @(negedge clk);
        m_r = capt(din, nar, b); m_cs = cs0_n;
        chk("R8 first capture", q_o, expq(m_r, nar, b));
    endtask

    task automatic step(logic [W-1:0] d, logic c0, logic c1, bit r9);
        string tag;
        din = d; cs0_n = c0; cs1_n = c1;
        if (!(c0 && c1)) begin m_r = capt(d, mode_dup, arr_sel); m_cs = c0; end
        @(negedge clk);
        if (c0 && c1)      tag = "R5 hold";
        else if (r9)       tag = "R9 tied select";
        else if (!mode_dup) tag = "R1 wide";
        else if (arr_sel)  tag = "R4 arrangement B";
        else               tag = "R3 arrangement A";
        chk(tag, q_o, expq(m_r, mode_dup, arr_sel));
        chk(r9 ? "R9 cs follow" : "R6 cs copy", {27'd0, cs_q_n}, {27'd0, m_cs});
        if (!mode_dup) chk("R2 pad low", {25'd0, q_o[O-1:W]}, '0);
    endtask

    task automatic sweep();
        for (int i = 0; i < W; i++) step(25'd1 << i, i[0], i[1], 1'b0);
        for (int i = 0; i < 120; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            step(seed[30:6], i[0], i[1], 1'b0);
        end
    endtask

    initial begin
        cfg(1'b0, 1'b0, 1'b0);
        sweep();
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            step(seed[31:7], seed[2], 1'b0, 1'b1);
        end
        cfg(1'b1, 1'b0, 1'b1);
        sweep();
        cfg(1'b1, 1'b1, 1'b1);
        sweep();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule